// File: doc/BRIEF.md
# Trace Start Lookup and Selector

This block sits beside the fetch stage of a processor that runs ahead by skipping whole traces. It keeps a set-associative table of trace candidates, each described by the PC where the trace begins, the PC where it ends, a short branch-history pattern and a small occurrence counter. The table is filled from outside through a preload port before the program runs. Every cycle in which a lookup is requested, the block indexes the table with the fetch PC and searches the set for ways whose start PC equals that PC.

Several candidates may begin at the same PC. The block prefers a candidate whose stored history pattern equals the current branch history. If none does, it prefers the candidate with the highest occurrence count. The registered result gives the trace end PC and a flat entry index, so that prediction data held in a separate array can be read with the same index. A separate confirm port reports each time a trace is actually used. The block then increments that entry's counter, or clears the whole group of entries that share its start PC once the counter would saturate.

Top module: `trace_start_sel`

## Requirements
- R1: After reset every entry is invalid, and every lookup misses until an entry is loaded; `hit_o` is 0 while reset is held.
- R2: A load with `ld_en` high writes the entry at `ld_idx` with the given start PC, end PC and history, marks it valid and sets its counter to 0. Reloading an index replaces the previous contents. The loader places each entry in the set given by its start PC (the upper `ld_idx` bits are the set, the low 2 bits are the way).
- R3: A lookup examines the set given by PC bits [6:2]. A way matches only if it is valid and its stored start PC equals the full 32-bit lookup PC.
- R4: The result of a lookup presented with `lk_en` high appears on the outputs after the next rising clock edge. A cycle with `lk_en` low yields `hit_o` = 0 one edge later.
- R5: Among matching ways, one whose stored history equals `lk_hist` is chosen, and `hist_match_o` is 1. If several do, the lowest way number wins.
- R6: If no matching way has an equal history, the matching way with the largest counter is chosen, and `hist_match_o` is 0. Equal counts go to the lowest way number.
- R7: On a hit, `end_pc_o` is the chosen entry's end PC and `idx_o` = set*4 + way. On a miss, `end_pc_o`, `idx_o` and `hist_match_o` are all 0.
- R8: A confirm with `cf_en` high on a valid entry adds 1 to that entry's 4-bit counter. A confirm on an invalid entry has no effect.
- R9: When a confirm would bring a counter to 15, every valid entry in that set whose start PC equals the confirmed entry's start PC gets its counter cleared to 0, the confirmed entry included. Other entries keep their counts, so no stored counter ever holds 15.
- R10: A confirm in the same cycle as a load is ignored.
- R11: A lookup sees the table contents from before any load or confirm presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Preload write strobe |
| ld_idx | input | 7 | Entry written: set in bits [6:2], way in bits [1:0] |
| ld_start_pc | input | 32 | Start PC of the loaded trace |
| ld_end_pc | input | 32 | End PC of the loaded trace |
| ld_hist | input | 8 | Branch-history pattern of the loaded trace |
| cf_en | input | 1 | Confirmed use of an entry |
| cf_idx | input | 7 | Index of the confirmed entry |
| lk_en | input | 1 | Lookup request |
| lk_pc | input | 32 | Fetch PC to look up |
| lk_hist | input | 8 | Current branch history |
| hit_o | output | 1 | Registered: a trace starts at the looked-up PC |
| end_pc_o | output | 32 | Registered end PC of the chosen trace |
| idx_o | output | 7 | Registered flat index of the chosen entry |
| hist_match_o | output | 1 | Registered: choice was made by history equality |

## Verification
The assertions assume that the loader respects the home-set rule: the set bits of `ld_idx` equal bits [6:2] of `ld_start_pc`. Without that, a loaded entry could never be found and the group clear would not cover all entries that share a start PC. The stimulus derives every load index from the start PC it carries, and draws its PCs from a few values that alias into two sets, so that shared start PCs, history ties and counter wraps all occur often. Confirms may name empty entries, and they overlap with loads and lookups in the same cycle; the model covers those cases.

// File: rtl/trace_sel_pkg.sv
package trace_sel_pkg;

    localparam int PC_W   = 32;
    localparam int HIST_W = 8;
    localparam int CNT_W  = 4;
    localparam int PC_LSB = 2;

    typedef logic [PC_W-1:0]   pc_t;
    typedef logic [HIST_W-1:0] hist_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef struct packed {
        logic  valid;
        pc_t   start_pc;
        pc_t   end_pc;
        hist_t hist;
        cnt_t  cnt;
    } trace_ent_t;

    localparam cnt_t CNT_TOP  = '1;
    localparam cnt_t CNT_WRAP = CNT_TOP - 1'b1;

    function automatic cnt_t cnt_bump(cnt_t c);
        return c + 1'b1;
    endfunction

endpackage

// File: rtl/trace_tbl_store.sv
module trace_tbl_store
    import trace_sel_pkg::*;
#(
    parameter  int NUM_SETS = 32,
    parameter  int NUM_WAYS = 4,
    localparam int SET_W    = $clog2(NUM_SETS),
    localparam int WAY_W    = $clog2(NUM_WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_en,
    input  logic [SET_W-1:0] ld_set,
    input  logic [WAY_W-1:0] ld_way,
    input  trace_ent_t       ld_ent,
    input  logic             cf_en,
    input  logic [SET_W-1:0] cf_set,
    input  logic [WAY_W-1:0] cf_way,
    input  logic [SET_W-1:0] rd_set,
    output trace_ent_t       rd_row [NUM_WAYS]
);

    trace_ent_t          tbl [NUM_SETS][NUM_WAYS];
    trace_ent_t          cf_ent;
    logic                cf_live;
    logic                cf_wrap;
    logic [NUM_WAYS-1:0] grp;

    assign cf_ent  = tbl[cf_set][cf_way];
    assign cf_live = cf_en && !ld_en && cf_ent.valid;
    assign cf_wrap = (cf_ent.cnt == CNT_WRAP);

    // Entries sharing the confirmed entry's start PC form its counter group.
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_grp
        assign grp[w] = tbl[cf_set][w].valid &&
                        (tbl[cf_set][w].start_pc == cf_ent.start_pc);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                for (int w = 0; w < NUM_WAYS; w++) begin
                    tbl[s][w] <= '0;
                end
            end
        end else if (ld_en) begin
            tbl[ld_set][ld_way] <= ld_ent;
        end else if (cf_live) begin
            if (cf_wrap) begin
                for (int w = 0; w < NUM_WAYS; w++) begin
                    if (grp[w]) begin
                        tbl[cf_set][w].cnt <= '0;
                    end
                end
            end else begin
                tbl[cf_set][cf_way].cnt <= cnt_bump(cf_ent.cnt);
            end
        end
    end

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_rd
        assign rd_row[w] = tbl[rd_set][w];
    end

    // Assertions
    assert_load_fresh_R2: assert property (@(posedge clk) disable iff (rst)
        ld_en |=> (tbl[$past(ld_set)][$past(ld_way)].valid &&
                   tbl[$past(ld_set)][$past(ld_way)].cnt == '0));

    assert_wrap_clears_self_R9: assert property (@(posedge clk) disable iff (rst)
        (cf_live && cf_wrap) |=> (tbl[$past(cf_set)][$past(cf_way)].cnt == '0));

    assert_bump_R8: assert property (@(posedge clk) disable iff (rst)
        (cf_live && !cf_wrap) |=>
            (tbl[$past(cf_set)][$past(cf_way)].cnt == cnt_bump($past(cf_ent.cnt))));

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_chk_s
        for (genvar w = 0; w < NUM_WAYS; w++) begin : g_chk_w
            assert_cnt_never_top_R9: assert property (@(posedge clk) disable iff (rst)
                tbl[s][w].cnt != CNT_TOP);
        end
    end

endmodule

// File: rtl/trace_way_match.sv
module trace_way_match
    import trace_sel_pkg::*;
#(
    parameter int NUM_WAYS = 4
) (
    input  trace_ent_t          row [NUM_WAYS],
    input  pc_t                 pc,
    input  hist_t               hist,
    output logic [NUM_WAYS-1:0] pc_hit,
    output logic [NUM_WAYS-1:0] hist_hit,
    output cnt_t                cnt [NUM_WAYS]
);

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        assign pc_hit[w]   = row[w].valid && (row[w].start_pc == pc);
        assign hist_hit[w] = (row[w].hist == hist);
        assign cnt[w]      = row[w].cnt;
    end

endmodule

// File: rtl/trace_way_pick.sv
module trace_way_pick
    import trace_sel_pkg::*;
#(
    parameter  int NUM_WAYS = 4,
    localparam int WAY_W    = $clog2(NUM_WAYS)
) (
    input  logic [NUM_WAYS-1:0] pc_hit,
    input  logic [NUM_WAYS-1:0] hist_hit,
    input  cnt_t                cnt [NUM_WAYS],
    output logic                any_hit,
    output logic [WAY_W-1:0]    sel_way,
    output logic                sel_by_hist
);

    logic             found_h;
    logic             found_c;
    logic [WAY_W-1:0] hway;
    logic [WAY_W-1:0] cway;
    cnt_t             best;

    always_comb begin
        found_h = 1'b0;
        hway    = '0;
        // Scan downward so the lowest matching way is the last one kept.
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (pc_hit[w] && hist_hit[w]) begin
                found_h = 1'b1;
                hway    = WAY_W'(w);
            end
        end
        found_c = 1'b0;
        cway    = '0;
        best    = '0;
        // Strict greater-than keeps the lowest way on equal counts.
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (pc_hit[w] && (!found_c || cnt[w] > best)) begin
                found_c = 1'b1;
                cway    = WAY_W'(w);
                best    = cnt[w];
            end
        end
        any_hit     = found_c;
        sel_by_hist = found_h;
        sel_way     = found_h ? hway : cway;
    end

    // Assertions
    always_comb begin
        if (any_hit) begin
            assert_pick_is_match_R3: assert (pc_hit[sel_way]);
        end
        if (sel_by_hist) begin
            assert_pick_hist_equal_R5: assert (hist_hit[sel_way] && any_hit);
        end
        if (any_hit && !sel_by_hist) begin
            for (int w = 0; w < NUM_WAYS; w++) begin
                if (pc_hit[w]) begin
                    assert_pick_max_count_R6: assert (cnt[w] <= cnt[sel_way]);
                end
            end
        end
    end

endmodule

// File: rtl/trace_start_sel.sv
module trace_start_sel
    import trace_sel_pkg::*;
#(
    parameter  int NUM_SETS = 32,
    parameter  int NUM_WAYS = 4,
    localparam int SET_W    = $clog2(NUM_SETS),
    localparam int WAY_W    = $clog2(NUM_WAYS),
    localparam int IDX_W    = SET_W + WAY_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [PC_W-1:0]   ld_start_pc,
    input  logic [PC_W-1:0]   ld_end_pc,
    input  logic [HIST_W-1:0] ld_hist,
    input  logic              cf_en,
    input  logic [IDX_W-1:0]  cf_idx,
    input  logic              lk_en,
    input  logic [PC_W-1:0]   lk_pc,
    input  logic [HIST_W-1:0] lk_hist,
    output logic              hit_o,
    output logic [PC_W-1:0]   end_pc_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              hist_match_o
);

    trace_ent_t          ld_ent;
    logic [SET_W-1:0]    lk_set;
    trace_ent_t          row [NUM_WAYS];
    logic [NUM_WAYS-1:0] pc_hit;
    logic [NUM_WAYS-1:0] hist_hit;
    cnt_t                way_cnt [NUM_WAYS];
    logic                any_hit;
    logic [WAY_W-1:0]    sel_way;
    logic                sel_by_hist;
    logic                take;

    assign ld_ent = '{valid: 1'b1, start_pc: ld_start_pc, end_pc: ld_end_pc,
                      hist: ld_hist, cnt: '0};
    assign lk_set = lk_pc[PC_LSB +: SET_W];

    trace_tbl_store #(
        .NUM_SETS (NUM_SETS),
        .NUM_WAYS (NUM_WAYS)
    ) store_i (
        .clk    (clk),
        .rst    (rst),
        .ld_en  (ld_en),
        .ld_set (ld_idx[IDX_W-1:WAY_W]),
        .ld_way (ld_idx[WAY_W-1:0]),
        .ld_ent (ld_ent),
        .cf_en  (cf_en),
        .cf_set (cf_idx[IDX_W-1:WAY_W]),
        .cf_way (cf_idx[WAY_W-1:0]),
        .rd_set (lk_set),
        .rd_row (row)
    );

    trace_way_match #(
        .NUM_WAYS (NUM_WAYS)
    ) match_i (
        .row      (row),
        .pc       (lk_pc),
        .hist     (lk_hist),
        .pc_hit   (pc_hit),
        .hist_hit (hist_hit),
        .cnt      (way_cnt)
    );

    trace_way_pick #(
        .NUM_WAYS (NUM_WAYS)
    ) pick_i (
        .pc_hit      (pc_hit),
        .hist_hit    (hist_hit),
        .cnt         (way_cnt),
        .any_hit     (any_hit),
        .sel_way     (sel_way),
        .sel_by_hist (sel_by_hist)
    );

    assign take = lk_en && any_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_o        <= 1'b0;
            end_pc_o     <= '0;
            idx_o        <= '0;
            hist_match_o <= 1'b0;
        end else begin
            hit_o        <= take;
            end_pc_o     <= take ? row[sel_way].end_pc : '0;
            idx_o        <= take ? {lk_set, sel_way} : '0;
            hist_match_o <= take && sel_by_hist;
        end
    end

    // Assertions
    assert_load_home_set_R2: assert property (@(posedge clk) disable iff (rst)
        ld_en |-> (ld_start_pc[PC_LSB +: SET_W] == ld_idx[IDX_W-1:WAY_W]));

    assert_hit_needs_lookup_R4: assert property (@(posedge clk) disable iff (rst)
        hit_o |-> $past(lk_en));

    assert_miss_zero_R7: assert property (@(posedge clk) disable iff (rst)
        !hit_o |-> (end_pc_o == '0 && idx_o == '0 && !hist_match_o));

    assert_idx_in_lookup_set_R7: assert property (@(posedge clk) disable iff (rst)
        hit_o |-> (idx_o[IDX_W-1:WAY_W] == $past(lk_pc[PC_LSB +: SET_W])));

endmodule

// File: tb/trace_start_sel_tb_top.sv
`timescale 1ns/1ps
module trace_start_sel_tb_top;

    localparam int NS = 32;
    localparam int NW = 4;
    localparam int IW = 7;
    localparam int NE = NS * NW;
    localparam int WRAP_AT = 14;

    logic        clk = 1'b0;
    logic        rst;
    logic        ld_en;
    logic [6:0]  ld_idx;
    logic [31:0] ld_start_pc;
    logic [31:0] ld_end_pc;
    logic [7:0]  ld_hist;
    logic        cf_en;
    logic [6:0]  cf_idx;
    logic        lk_en;
    logic [31:0] lk_pc;
    logic [7:0]  lk_hist;
    logic        hit_o;
    logic [31:0] end_pc_o;
    logic [6:0]  idx_o;
    logic        hist_match_o;

    always #2.5 clk = ~clk;

    trace_start_sel dut_i (
        .clk          (clk),
        .rst          (rst),
        .ld_en        (ld_en),
        .ld_idx       (ld_idx),
        .ld_start_pc  (ld_start_pc),
        .ld_end_pc    (ld_end_pc),
        .ld_hist      (ld_hist),
        .cf_en        (cf_en),
        .cf_idx       (cf_idx),
        .lk_en        (lk_en),
        .lk_pc        (lk_pc),
        .lk_hist      (lk_hist),
        .hit_o        (hit_o),
        .end_pc_o     (end_pc_o),
        .idx_o        (idx_o),
        .hist_match_o (hist_match_o)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    bit          m_valid [NE];
    logic [31:0] m_start [NE];
    logic [31:0] m_end   [NE];
    logic [7:0]  m_hist  [NE];
    int          m_cnt   [NE];

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One clock cycle: drive at a falling edge, predict from the model state
    // before the update, then check at the next falling edge.
    task automatic step(input bit ld, input int lidx, input logic [31:0] ls,
                        input logic [31:0] le, input logic [7:0] lh,
                        input bit cf, input int cidx,
                        input bit lk, input logic [31:0] lpc, input logic [7:0] lhist,
                        input string req);
        bit          eh;
        bit          ehm;
        int          ei;
        logic [31:0] ee;
        int          s;
        int          hw;
        int          bw;
        int          base;
        ld_en = ld; ld_idx = IW'(lidx); ld_start_pc = ls; ld_end_pc = le; ld_hist = lh;
        cf_en = cf; cf_idx = IW'(cidx);
        lk_en = lk; lk_pc = lpc; lk_hist = lhist;
        eh = 1'b0; ehm = 1'b0; ei = 0; ee = '0;
        if (lk) begin
            s  = int'((lpc >> 2) % NS);
            hw = -1;
            bw = -1;
            for (int w = 0; w < NW; w++) begin
                if (m_valid[s*NW+w] && m_start[s*NW+w] == lpc) begin
                    if (hw < 0 && m_hist[s*NW+w] == lhist) hw = w;
                    if (bw < 0 || m_cnt[s*NW+w] > m_cnt[s*NW+bw]) bw = w;
                end
            end
            if (bw >= 0) begin
                eh  = 1'b1;
                ehm = (hw >= 0);
                ei  = s * NW + ((hw >= 0) ? hw : bw);
                ee  = m_end[ei];
            end
        end
        if (ld) begin
            m_valid[lidx] = 1'b1; m_start[lidx] = ls; m_end[lidx] = le;
            m_hist[lidx] = lh; m_cnt[lidx] = 0;
        end else if (cf && m_valid[cidx]) begin
            if (m_cnt[cidx] == WRAP_AT) begin
                base = (cidx / NW) * NW;
                for (int w = 0; w < NW; w++) begin
                    if (m_valid[base+w] && m_start[base+w] == m_start[cidx]) m_cnt[base+w] = 0;
                end
            end else begin
                m_cnt[cidx]++;
            end
        end
        @(negedge clk);
        chk(req, "hit_o", 32'(hit_o), 32'(eh));
        chk(req, "end_pc_o", end_pc_o, ee);
        chk(req, "idx_o", 32'(idx_o), 32'(ei));
        chk(req, "hist_match_o", 32'(hist_match_o), 32'(ehm));
        ld_en = 1'b0; cf_en = 1'b0; lk_en = 1'b0;
    endtask

    task automatic do_load(input int idx, input logic [31:0] s, input logic [31:0] e,
                           input logic [7:0] h, input string req);
        step(1'b1, idx, s, e, h, 1'b0, 0, 1'b0, '0, '0, req);
    endtask

    task automatic do_cf(input int idx, input string req);
        step(1'b0, 0, '0, '0, '0, 1'b1, idx, 1'b0, '0, '0, req);
    endtask

    task automatic do_lk(input logic [31:0] pc, input logic [7:0] h, input string req);
        step(1'b0, 0, '0, '0, '0, 1'b0, 0, 1'b1, pc, h, req);
    endtask

    function automatic logic [31:0] xs(input logic [31:0] v);
        logic [31:0] r;
        r = v;
        r = r ^ (r << 13);
        r = r ^ (r >> 17);
        r = r ^ (r << 5);
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    localparam logic [31:0] PC_P = 32'h1000_0014;   // set 5
    localparam logic [31:0] PC_Q = 32'h2000_0014;   // set 5

    initial begin
        logic [31:0] r;
        int          op;
        int          st;
        int          way;
        logic [31:0] pc;
        logic [7:0]  h;
        for (int i = 0; i < NE; i++) begin
            m_valid[i] = 1'b0; m_start[i] = '0; m_end[i] = '0; m_hist[i] = '0; m_cnt[i] = 0;
        end
        rst = 1'b1;
        ld_en = 1'b0; ld_idx = '0; ld_start_pc = '0; ld_end_pc = '0; ld_hist = '0;
        cf_en = 1'b0; cf_idx = '0; lk_en = 1'b0; lk_pc = '0; lk_hist = '0;
        repeat (3) @(negedge clk);
        chk("R1", "hit_o in reset", 32'(hit_o), 32'd0);
        rst = 1'b0;

        // R1: empty table misses
        do_lk(32'h0000_0000, 8'h00, "R1");
        do_lk(PC_P, 8'h00, "R1");

        // R2 / R7: load then hit with end PC and flat index
        do_load(22, PC_P, 32'h1000_0400, 8'h77, "R2");
        do_lk(PC_P, 8'h00, "R7");
        // R3: same set, different start PC misses
        do_lk(PC_P + 32'h80, 8'h00, "R3");
        // R4: no lookup yields no hit
        step(1'b0, 0, '0, '0, '0, 1'b0, 0, 1'b0, PC_P, 8'h77, "R4");

        // R5: shared start PC, history selects; two equal -> lowest way
        do_load(20, PC_Q, 32'h2000_0100, 8'h11, "R2");
        do_load(21, PC_Q, 32'h2000_0200, 8'h22, "R2");
        do_load(23, PC_Q, 32'h2000_0300, 8'h22, "R2");
        do_lk(PC_Q, 8'h22, "R5");
        do_lk(PC_Q, 8'h11, "R5");

        // R6 / R8: no history match, count decides
        do_lk(PC_Q, 8'h33, "R6");
        do_cf(23, "R8");
        do_cf(23, "R8");
        do_lk(PC_Q, 8'h33, "R8");
        do_cf(21, "R8");
        do_cf(21, "R8");
        do_lk(PC_Q, 8'h33, "R6");
        do_cf(3, "R8");   // invalid entry: no effect
        do_lk(PC_Q, 8'h33, "R8");

        // R9: drive way 3 up to the wrap, whole group clears
        for (int k = 0; k < 12; k++) do_cf(23, "R8");
        do_lk(PC_Q, 8'h33, "R6");
        do_cf(23, "R9");
        do_lk(PC_Q, 8'h33, "R9");
        do_lk(PC_P, 8'h00, "R9");

        // R10: confirm together with a load is dropped
        step(1'b1, 0, 32'h0000_0000, 32'h0000_0040, 8'h01, 1'b1, 21, 1'b0, '0, '0, "R10");
        do_lk(PC_Q, 8'h33, "R10");
        do_cf(21, "R10");
        do_lk(PC_Q, 8'h33, "R10");

        // R11: lookup sees the state before a same-cycle confirm
        step(1'b0, 0, '0, '0, '0, 1'b1, 23, 1'b1, PC_Q, 8'h33, "R11");
        step(1'b0, 0, '0, '0, '0, 1'b1, 23, 1'b1, PC_Q, 8'h33, "R11");
        do_lk(PC_Q, 8'h33, "R11");
        step(1'b1, 21, 32'h3000_0014, 32'h3000_0500, 8'h22, 1'b0, 0, 1'b1, PC_Q, 8'h22, "R11");
        do_lk(PC_Q, 8'h22, "R2");

        // Sweep over two aliased sets with few start PCs
        r = 32'h1234_5678;
        for (int i = 0; i < 6000; i++) begin
            r   = xs(r);
            op  = int'(r % 8);
            st  = r[3] ? 17 : 3;
            way = int'(r[7:6]);
            pc  = (32'(r[5:4]) << 12) | (32'(st) << 2);
            h   = r[8] ? 8'h5A : 8'hA5;
            if (op < 2)
                do_load(st * NW + way, pc, {r[31:10], 10'h0}, h, "R2");
            else if (op < 5)
                do_cf(st * NW + way, "R9");
            else if (op < 7)
                do_lk(pc, h, "R6");
            else
                step(1'b0, 0, '0, '0, '0, 1'b1, st * NW + way, 1'b1, pc, h, "R11");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule